// File: doc/BRIEF.md
# Audio Frame Rate Generator

This block turns one master clock into the frame-rate strobes that pace an audio converter pair. A single-cycle strobe marks each frame of the analog-to-digital path, and a separate strobe marks each frame of the digital-to-analog path. Each path has its own down-counter, so the two paths can run at different rates. A third output is a clock-enable pulse train for an external clock pin. It runs at the master rate, or at half that rate with a 50% duty cycle.

An 8-bit control word is loaded through a write port. The port is 9 bits wide, but the top bit is reserved and is dropped. The control word picks one of two clock modes:

- In the conventional mode, a frame lasts 256 or 384 master clocks, doubled when the rate code asks for it.
- In the mode meant for a 12 MHz clock shared with a serial-bus host, the frame lengths are not powers of two. They are 250, 272, 125, 136, 1500 and 1496 master clocks, which give 48, 44.117, 96, 88.235, 8 and 8.021 kHz.

An input-halving bit slows the whole rate generator to every other master clock. An output-halving bit acts on the clock output alone.

A new control word never cuts a running frame short. Each path finishes its current frame with the old length and reloads from the new word at its own frame boundary.

Top module: `frame_clock_gen`

## Requirements
- R1: After reset the control word is 0x020, so the conventional mode applies with a frame length of 256. Both strobes then repeat every 256 master clocks, and the clock output is held high. While reset is asserted both strobes are low.
- R2: In the conventional mode (bit 0 = 0), the frame length is a base times a multiplier. The base is 256 when bit 1 is 0 and 384 when bit 1 is 1. The multiplier is 2 when bit 2 (the low bit of the rate code in bits 5:2) is 1, and 1 otherwise.
- R3: In the host-clock mode (bit 0 = 1), the rate codes map to frame lengths as follows:
  - code 0x7 gives 125
  - code 0xF gives 136
  - code 0x8 gives 272
  - code 0x3 gives 1500
  - code 0xB gives 1496
  - code 0x0 gives 250 when bit 1 is 0 and 272 when bit 1 is 1

  Each length applies to both paths.
- R4: In the host-clock mode, rate code 0x1 gives the ADC path the code-0x0 length (250 with bit 1 = 0) and gives the DAC path 1500.
- R5: In the host-clock mode, any rate code not listed in R3 or R4 behaves as code 0x0.
- R6: With bit 6 set, every strobe period is twice the length selected by R2 to R5.
- R7: With bit 7 set, the clock output toggles on every master clock, giving a 50% duty cycle at half rate. With bit 7 clear it stays high. Bit 7 has no effect on the strobes.
- R8: Each strobe is high for exactly one master clock per frame.
- R9: A write during a frame leaves that frame's length unchanged. The next frame uses the new length.
- R10: Bit 8 of the write data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Control word write enable |
| cfg_wdata_i | input | 9 | Control word write data; bit 8 reserved |
| adc_frame_o | output | 1 | ADC path frame strobe |
| dac_frame_o | output | 1 | DAC path frame strobe |
| clk_out_o | output | 1 | Clock-output enable pulse train |

## Verification
The bench builds the block with its default parameters. These are a 12-bit counter and bases of 250 and 272 for the host-clock mode, and 256 and 384 for the conventional mode. With these values, every frame length, including the 3000-clock frame given by code 0x3 with input halving, fits in a short run without counter wrap. Every supported code is measured with input halving off and on. The measurements also cover a write that lands mid-frame, the reserved bit, and the clock output in both states.

// File: rtl/faclk_pkg.sv
package faclk_pkg;

  localparam int unsigned CFG_W = 9;

  typedef struct packed {
    logic       out_half;  // bit 7
    logic       in_half;   // bit 6
    logic [3:0] code;      // bits 5:2
    logic       osr_alt;   // bit 1
    logic       usb_mode;  // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = 8'h20;

endpackage

// File: rtl/frame_ratio_decode.sv
module frame_ratio_decode
  import faclk_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned USB_LO = 250,
  parameter int unsigned USB_HI = 272,
  parameter int unsigned NRM_LO = 256,
  parameter int unsigned NRM_HI = 384
) (
  input  logic             usb_mode_i,
  input  logic             osr_alt_i,
  input  logic [3:0]       code_i,
  output logic [CNT_W-1:0] adc_ratio_o,
  output logic [CNT_W-1:0] dac_ratio_o
);

  localparam logic [CNT_W-1:0] R_ULO  = CNT_W'(USB_LO);
  localparam logic [CNT_W-1:0] R_UHI  = CNT_W'(USB_HI);
  localparam logic [CNT_W-1:0] R_NLO  = CNT_W'(NRM_LO);
  localparam logic [CNT_W-1:0] R_NHI  = CNT_W'(NRM_HI);
  localparam logic [CNT_W-1:0] R_UFL  = CNT_W'(USB_LO / 2);
  localparam logic [CNT_W-1:0] R_UFH  = CNT_W'(USB_HI / 2);
  localparam logic [CNT_W-1:0] R_USL  = CNT_W'(USB_LO * 6);
  localparam logic [CNT_W-1:0] R_USH  = CNT_W'((USB_HI * 11) / 2);

  logic [CNT_W-1:0] base;

  always_comb begin
    if (usb_mode_i) base = osr_alt_i ? R_UHI : R_ULO;
    else            base = osr_alt_i ? R_NHI : R_NLO;

    adc_ratio_o = base;
    dac_ratio_o = base;
    if (!usb_mode_i) begin
      if (code_i[0]) begin
        adc_ratio_o = base << 1;
        dac_ratio_o = base << 1;
      end
    end else begin
      unique case (code_i)
        4'h8: begin adc_ratio_o = R_UHI; dac_ratio_o = R_UHI; end
        4'h7: begin adc_ratio_o = R_UFL; dac_ratio_o = R_UFL; end
        4'hF: begin adc_ratio_o = R_UFH; dac_ratio_o = R_UFH; end
        4'h3: begin adc_ratio_o = R_USL; dac_ratio_o = R_USL; end
        4'hB: begin adc_ratio_o = R_USH; dac_ratio_o = R_USH; end
        4'h1: begin adc_ratio_o = base;  dac_ratio_o = R_USL; end
        default: begin adc_ratio_o = base; dac_ratio_o = base; end
      endcase
    end
  end

endmodule

// File: rtl/rate_enable_gen.sv
module rate_enable_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_half_i,
  output logic ce_o
);

  logic half_q, half_d;

  always_comb half_d = ~half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= half_d;
  end

  assign ce_o = ~in_half_i | half_q;

  // R6: under input halving the enable never holds for two clocks
  p_half_rate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_o && in_half_i) |=> (!in_half_i || !ce_o));

endmodule

// File: rtl/frame_divider.sv
module frame_divider #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             strobe_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stb_q, stb_d;

  always_comb begin
    cnt_d = cnt_q;
    stb_d = 1'b0;
    if (ce_i) begin
      if (cnt_q == '0) begin
        cnt_d = ratio_i - 1'b1;
        stb_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign strobe_o = stb_q;

  // R8: one-clock strobe
  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  // R9: a running frame keeps counting down regardless of the ratio input
  p_countdown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && cnt_q != '0) |=> (!strobe_o && cnt_q == $past(cnt_q) - 1'b1));

  // R9: reload picks up the ratio only at the boundary
  p_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && cnt_q == '0) |=> (strobe_o && cnt_q == $past(ratio_i) - 1'b1));

endmodule

// File: rtl/clkout_div.sv
module clkout_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_half_i,
  output logic clk_o
);

  logic clk_q, clk_d;

  always_comb clk_d = out_half_i ? ~clk_q : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b1;
    else         clk_q <= clk_d;
  end

  assign clk_o = clk_q;

  // R7: half mode toggles every master clock
  p_clkout_half_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_half_i |=> (clk_o != $past(clk_o)));

  // R7: full mode holds the enable high
  p_clkout_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_half_i |=> clk_o);

endmodule

// File: rtl/frame_clock_gen.sv
module frame_clock_gen
  import faclk_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned USB_LO = 250,
  parameter int unsigned USB_HI = 272,
  parameter int unsigned NRM_LO = 256,
  parameter int unsigned NRM_HI = 384
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             adc_frame_o,
  output logic             dac_frame_o,
  output logic             clk_out_o
);

  localparam int unsigned NPATH = 2;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic rst_n_int;
  assign rst_n_int = rst_sync_q;

  // control word; reserved bit dropped (R10)
  ctrl_t ctrl_q, ctrl_d;

  always_comb ctrl_d = cfg_we_i ? ctrl_t'(cfg_wdata_i[7:0]) : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) ctrl_q <= CTRL_RESET;
    else            ctrl_q <= ctrl_d;
  end

  logic [CNT_W-1:0] ratio [NPATH];
  logic [NPATH-1:0] stb;
  logic             ce;

  frame_ratio_decode #(
    .CNT_W (CNT_W), .USB_LO(USB_LO), .USB_HI(USB_HI),
    .NRM_LO(NRM_LO), .NRM_HI(NRM_HI)
  ) u_decode (
    .usb_mode_i (ctrl_q.usb_mode),
    .osr_alt_i  (ctrl_q.osr_alt),
    .code_i     (ctrl_q.code),
    .adc_ratio_o(ratio[0]),
    .dac_ratio_o(ratio[1])
  );

  rate_enable_gen u_rate_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .in_half_i(ctrl_q.in_half),
    .ce_o     (ce)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    frame_divider #(.CNT_W(CNT_W)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_int),
      .ce_i    (ce),
      .ratio_i (ratio[p]),
      .strobe_o(stb[p])
    );
  end

  clkout_div u_clkout (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .out_half_i(ctrl_q.out_half),
    .clk_o     (clk_out_o)
  );

  assign adc_frame_o = stb[0];
  assign dac_frame_o = stb[1];

  // R10: a write carrying the reserved bit stores only the low byte
  p_reserved_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (cfg_we_i && cfg_wdata_i[8]) |=> (ctrl_q == $past(cfg_wdata_i[7:0])));

  // R1: strobes stay quiet while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_n_int |-> (!adc_frame_o && !dac_frame_o));

endmodule

// File: tb/frame_clock_gen_test.sv
`timescale 1ns/1ps
module frame_clock_gen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [8:0] wd;
  wire        adc, dac, cko;

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  int    adc_q[$], dac_q[$];
  string adc_t[$], dac_t[$];
  int    adc_cnt = 0, dac_cnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  frame_clock_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wd),
    .adc_frame_o(adc), .dac_frame_o(dac), .clk_out_o(cko)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: measure strobe intervals, compare to queued expectations
  always @(negedge clk) begin
    if (mon_on) begin
      adc_cnt++;
      dac_cnt++;
      if (adc) begin
        if (adc_q.size() > 0) begin
          int e; string t;
          e = adc_q.pop_front(); t = adc_t.pop_front();
          check(adc_cnt == e, {t, " adc period"}, adc_cnt, e);
        end
        adc_cnt = 0;
      end
      if (dac) begin
        if (dac_q.size() > 0) begin
          int e; string t;
          e = dac_q.pop_front(); t = dac_t.pop_front();
          check(dac_cnt == e, {t, " dac period"}, dac_cnt, e);
        end
        dac_cnt = 0;
      end
    end
  end

  task automatic write_cfg(input logic [8:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_strobe(input bit is_dac);
    while (!(is_dac ? dac : adc)) @(negedge clk);
  endtask

  task automatic sync_push(input bit is_dac, input int e, input string t);
    wait_strobe(is_dac);
    @(posedge clk);
    if (is_dac) begin dac_q.push_back(e); dac_t.push_back(t); end
    else        begin adc_q.push_back(e); adc_t.push_back(t); end
  endtask

  task automatic drain();
    while (adc_q.size() > 0 || dac_q.size() > 0) @(negedge clk);
  endtask

  task automatic run_case(input logic [8:0] cfg, input int ea, input int ed, input string t);
    write_cfg(cfg);
    fork
      sync_push(1'b0, ea, t);
      sync_push(1'b1, ed, t);
    join
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // case table: config, adc length, dac length, requirement
  int    c_cfg[15] = '{'h020, 'h002, 'h004, 'h006, 'h00C,
                       'h001, 'h003, 'h021, 'h01D, 'h03D,
                       'h00D, 'h02D, 'h005, 'h015, 'h039};
  int    c_adc[15] = '{256, 384, 512, 768, 512,
                       250, 272, 272, 125, 136,
                       1500, 1496, 250, 250, 250};
  int    c_dac[15] = '{256, 384, 512, 768, 512,
                       250, 272, 272, 125, 136,
                       1500, 1496, 1500, 250, 250};
  string c_req[15] = '{"R2", "R2", "R2", "R2", "R2",
                       "R3", "R3", "R3", "R3", "R3",
                       "R3", "R3", "R4", "R5", "R5"};

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; wd = '0;
    repeat (5) @(negedge clk);
    // R1: strobes low in reset
    check(!adc && !dac, "R1 reset strobes", int'(adc) + int'(dac), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: default period and clock output
    fork
      sync_push(1'b0, 256, "R1");
      sync_push(1'b1, 256, "R1");
    join
    drain();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(cko == 1'b1, "R1 clk_out high", int'(cko), 1);
    end

    // R8: strobe width
    wait_strobe(1'b0);
    @(negedge clk);
    check(!adc, "R8 adc width", int'(adc), 0);
    wait_strobe(1'b1);
    @(negedge clk);
    check(!dac, "R8 dac width", int'(dac), 0);

    // R2..R6: every code, input halving off and on
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < 15; k++) begin
        run_case(9'(c_cfg[k] | (d << 6)), c_adc[k] * (d + 1), c_dac[k] * (d + 1),
                 d ? "R6" : c_req[k]);
      end
    end

    // R7: output halving
    run_case(9'h0A0, 256, 256, "R7");
    begin
      logic prev;
      int ones;
      @(negedge clk); prev = cko; ones = int'(cko);
      for (int i = 0; i < 7; i++) begin
        @(negedge clk);
        check(cko != prev, "R7 clk_out toggle", int'(cko), int'(!prev));
        prev = cko; ones += int'(cko);
      end
      check(ones == 4, "R7 clk_out duty", ones, 4);
    end
    run_case(9'h020, 256, 256, "R7");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(cko == 1'b1, "R7 clk_out full", int'(cko), 1);
    end

    // R9: write mid-frame, current frame keeps old length
    wait_strobe(1'b0);
    @(posedge clk);
    adc_q.push_back(256); adc_t.push_back("R9 old");
    adc_q.push_back(384); adc_t.push_back("R9 new");
    repeat (20) @(negedge clk);
    write_cfg(9'h022);
    drain();

    // R10: reserved bit ignored
    run_case(9'h120, 256, 256, "R10");
    run_case(9'h104, 512, 512, "R10");

    finish_run();
  end

endmodule